// File: doc/BRIEF.md
# Occupancy Event Filtering Performance Counter

This block is a single performance-monitor counter with its control word. Every clock it sees two candidate event sources: a multi-bit occupancy increment (for instance the number of cores sitting in a particular power state during that cycle) and a one-bit ordinary event. The top bit of an 8-bit event-select field picks which source drives the 48-bit counter.

When the occupancy source is chosen, the increment is tested against a 5-bit programmable threshold. The compare result can then be inverted, and an optional transition detector follows it. With the detector on, the counter advances once per qualifying transition rather than once per qualifying cycle. A simple register port writes and reads back both the control word and the counter. Writing a dedicated bit of the control word clears the counter.

Top module: `occ_filter_counter`

## Requirements
- R1: After reset, the control word and the counter both read as zero.
- R2: The control word holds the event select in bits [7:0], the threshold in [28:24], compare invert in bit 30 and transition detect in bit 31. Reads return these fields. Bit 29 and every other unused bit, including bit 17, always read 0, and writes to them have no effect.
- R3: When event-select bit 7 is 0, the counter advances by one in each cycle that `evt_in` is 1. `occ_inc` and the threshold controls have no effect.
- R4: When event-select bit 7 is 1 and both invert and detect are 0, the counter advances by one in each cycle where `occ_inc` >= threshold. A threshold of 0 therefore counts every cycle.
- R5: When event-select bit 7 is 1, invert is 1 and detect is 0, the counter advances by one in each cycle where `occ_inc` < threshold.
- R6: When event-select bit 7 is 1, detect is 1 and invert is 0, the counter advances by one only in a cycle where (`occ_inc` >= threshold) is true and was false in the previous cycle.
- R7: When event-select bit 7 is 1 and both detect and invert are 1, the counter advances by one only in a cycle where (`occ_inc` >= threshold) is false and was true in the previous cycle.
- R8: The transition history resets to 0 and is updated every cycle even while detect is off. Turning detect on while the filtered condition is already steadily true produces no count.
- R9: A control write with bit 17 set to 1 sets the counter to 0 at that clock edge, and any increment from that cycle is lost.
- R10: A counter write (`wr_sel`=1) loads `wr_data[47:0]`, ignores the upper bits, and takes priority over any increment in the same cycle.
- R11: The counter is 48 bits wide and wraps from 2^48-1 to 0.
- R12: A control write takes effect from the following cycle. Reads are combinational: `rd_sel`=0 selects the control word and `rd_sel`=1 selects the counter, zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_inc | input | 5 | Per-cycle occupancy increment |
| evt_in | input | 1 | Per-cycle ordinary event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 counter |
| wr_data | input | 64 | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 counter |
| rd_data | output | 64 | Read data (combinational) |

## Verification
A wrong transition history or a mis-filtered condition shows up as a counter value that leaves the expected sequence at the next clock edge after the faulty cycle. The bench reads both the control word and the counter on every clock, so any such error is caught within one cycle. Stale or wrongly merged control fields appear at once on a control-word read. A missed clear, load or wrap appears in the counter read that follows the edge where it should have happened.

// File: rtl/occ_pmon_pkg.sv
package occ_pmon_pkg;

    localparam int THR_W       = 5;
    localparam int EVSEL_W     = 8;
    localparam int CTL_W       = 32;
    localparam int EDGE_BIT    = 31;
    localparam int INV_BIT     = 30;
    localparam int RSV_BIT     = 29;
    localparam int THR_LSB     = 24;
    localparam int CLR_BIT     = 17;
    localparam int OCC_SEL_BIT = 7;

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_CNT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic               edge_en;
        logic               inv_en;
        logic [THR_W-1:0]   thr;
        logic [EVSEL_W-1:0] evsel;
    } ctl_t;

endpackage

// File: rtl/occ_ctrl_reg.sv
module occ_ctrl_reg
    import occ_pmon_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl,
    output logic              clr_pulse,
    output logic [DATA_W-1:0] ctl_word
);

    typedef struct packed {
        ctl_t ctl;
    } state_t;

    state_t st_d, st_q;
    logic   ctl_wr;
    logic   unused_wr;

    assign ctl_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
    assign unused_wr = ^{wr_data[DATA_W-1:CTL_W], wr_data[RSV_BIT],
                         wr_data[THR_LSB-1:CLR_BIT+1], wr_data[CLR_BIT-1:EVSEL_W]};

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl.edge_en = wr_data[EDGE_BIT];
            st_d.ctl.inv_en  = wr_data[INV_BIT];
            st_d.ctl.thr     = wr_data[THR_LSB +: THR_W];
            st_d.ctl.evsel   = wr_data[EVSEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl       = st_q.ctl;
    assign clr_pulse = ctl_wr && wr_data[CLR_BIT];

    always_comb begin
        ctl_word                        = '0;
        ctl_word[EDGE_BIT]              = st_q.ctl.edge_en;
        ctl_word[INV_BIT]               = st_q.ctl.inv_en;
        ctl_word[THR_LSB +: THR_W]      = st_q.ctl.thr;
        ctl_word[EVSEL_W-1:0]           = st_q.ctl.evsel;
    end

    // R12: control fields change only on a control write
    a_r12_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(st_q.ctl));

    // R2: a control write is reflected in the stored fields
    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> st_q.ctl.thr == $past(wr_data[THR_LSB +: THR_W]));

endmodule

// File: rtl/occ_event_filter.sv
module occ_event_filter
    import occ_pmon_pkg::*;
#(
    parameter int OCC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl,
    input  logic [OCC_W-1:0] occ_inc,
    input  logic             evt_in,
    output logic             hit
);

    localparam int CMP_W = (OCC_W > THR_W) ? OCC_W : THR_W;

    typedef struct packed {
        logic hist;
    } state_t;

    state_t            st_d, st_q;
    logic [CMP_W-1:0]  occ_ext;
    logic [CMP_W-1:0]  thr_ext;
    logic              ge_thr;
    logic              cond;
    logic              occ_mode;

    assign occ_ext  = CMP_W'(occ_inc);
    assign thr_ext  = CMP_W'(ctl.thr);
    assign occ_mode = ctl.evsel[OCC_SEL_BIT];

    always_comb begin
        ge_thr    = (occ_ext >= thr_ext);
        cond      = ge_thr ^ ctl.inv_en;
        st_d.hist = cond;
        if (!occ_mode)         hit = evt_in;
        else if (ctl.edge_en)  hit = cond && !st_q.hist;
        else                   hit = cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: in transition mode a hit cannot repeat while the configuration holds
    a_r6_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_mode && ctl.edge_en && hit) |=> (!hit || !$stable(ctl)));

    // R3: ordinary event mode ignores the occupancy input
    a_r3_plain_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (!occ_mode && !evt_in) |-> !hit);

endmodule

// File: rtl/occ_count_reg.sv
module occ_count_reg #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld)        st_d.cnt = ld_data;
        else if (clr)  st_d.cnt = '0;
        else if (inc)  st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R11: wrap from all ones to zero
    a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && inc && !ld && !clr) |=> st_q.cnt == '0);

    // R9: clear empties the counter
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld) |=> st_q.cnt == '0);

    // R10: load wins over everything
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> st_q.cnt == $past(ld_data));

    // R4: without load or clear the counter steps by at most one
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !clr) |=> (st_q.cnt == $past(st_q.cnt) ||
                           st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

endmodule

// File: rtl/occ_filter_counter.sv
module occ_filter_counter
    import occ_pmon_pkg::*;
#(
    parameter int OCC_W  = 5,
    parameter int CNT_W  = 48,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OCC_W-1:0]  occ_inc,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    ctl_t              ctl;
    logic              clr_pulse;
    logic [DATA_W-1:0] ctl_word;
    logic              hit;
    logic              cnt_ld;
    logic [CNT_W-1:0]  cnt;

    assign cnt_ld = wr_en && (reg_sel_e'(wr_sel) == SEL_CNT);

    occ_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ctl       (ctl),
        .clr_pulse (clr_pulse),
        .ctl_word  (ctl_word)
    );

    occ_event_filter #(.OCC_W(OCC_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .occ_inc (occ_inc),
        .evt_in  (evt_in),
        .hit     (hit)
    );

    occ_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (hit),
        .clr     (clr_pulse),
        .ld      (cnt_ld),
        .ld_data (wr_data[CNT_W-1:0]),
        .cnt     (cnt)
    );

    always_comb begin
        rd_data = '0;
        if (reg_sel_e'(rd_sel) == SEL_CNT) rd_data[CNT_W-1:0] = cnt;
        else                               rd_data = ctl_word;
    end

endmodule

// File: tb/occ_filter_counter_tb_top.sv
`timescale 1ns/1ps
module occ_filter_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  occ_inc = '0;
    logic        evt_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // reference model state
    logic [7:0]  m_evsel = '0;
    int          m_thr = 0;
    bit          m_inv = 0;
    bit          m_edge = 0;
    bit          m_prev = 0;
    logic [47:0] m_cnt = '0;

    always #2.5 clk = ~clk;

    occ_filter_counter dut_i (
        .clk(clk), .rst_n(rst_n), .occ_inc(occ_inc), .evt_in(evt_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_ctl();
        logic [63:0] w = '0;
        w[31]    = m_edge;
        w[30]    = m_inv;
        w[28:24] = 5'(m_thr);
        w[7:0]   = m_evsel;
        return w;
    endfunction

    task automatic read_both(string t);
        rd_sel = 1'b0; #0.5;
        chk({t, " ctl"}, rd_data, exp_ctl());
        rd_sel = 1'b1; #0.5;
        chk({t, " cnt"}, rd_data, {16'h0, m_cnt});
    endtask

    // one clock: model next state from current inputs, then compare
    task automatic tick();
        bit c, h;
        logic [47:0] nc;
        c = ((int'(occ_inc) >= m_thr) != m_inv);
        if (m_evsel[7]) h = m_edge ? (c && !m_prev) : c;
        else            h = evt_in;
        if (wr_en && wr_sel)             nc = wr_data[47:0];
        else if (wr_en && wr_data[17])   nc = '0;
        else                             nc = m_cnt + 48'(h);
        @(posedge clk);
        @(negedge clk);
        m_prev = c;
        m_cnt  = nc;
        if (wr_en && !wr_sel) begin
            m_edge  = wr_data[31];
            m_inv   = wr_data[30];
            m_thr   = int'(wr_data[28:24]);
            m_evsel = wr_data[7:0];
        end
        wr_en = 1'b0;
        read_both(tag);
    endtask

    task automatic wr(bit sel, logic [63:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
    endtask

    task automatic run_occ(int n);
        for (int i = 0; i < n; i++) begin
            occ_inc = 5'($urandom_range(0, 7));
            evt_in  = 1'($urandom);
            tick();
        end
    endtask

    initial begin
        #500000;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        read_both("R1 reset");

        // R2 / R9: write all ones; reserved, bit 17 and gaps read 0, counter cleared
        tag = "R2";
        wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_sel = 1'b0; #0.5;
        chk("R2 layout", rd_data, 64'h0000_0000_DF00_00FF);

        // R3: ordinary event, occupancy ignored
        tag = "R3";
        wr(1'b0, 64'h0000_0000_1F00_0005);
        wr(1'b1, 64'h0);
        for (int i = 0; i < 10; i++) begin
            occ_inc = 5'd31; evt_in = (i % 3 != 0); tick();
        end
        rd_sel = 1'b1; #0.5;
        chk("R3 count", rd_data, 64'd6);
        run_occ(20);

        // R4: occ >= 3
        tag = "R4";
        wr(1'b0, 64'h0000_0000_0300_0080);
        wr(1'b1, 64'h0);
        for (int i = 0; i < 8; i++) begin occ_inc = 5'(i); tick(); end
        rd_sel = 1'b1; #0.5;
        chk("R4 sweep", rd_data, 64'd5);
        run_occ(30);
        wr(1'b0, 64'h0000_0000_0000_0080);   // threshold 0 counts all
        run_occ(10);

        // R5: occ < 3
        tag = "R5";
        wr(1'b0, 64'h0000_0000_4300_0080);
        wr(1'b1, 64'h0);
        for (int i = 0; i < 8; i++) begin occ_inc = 5'(i); tick(); end
        rd_sel = 1'b1; #0.5;
        chk("R5 sweep", rd_data, 64'd3);
        run_occ(30);

        // R6: rising transitions of occ >= 3
        tag = "R6";
        wr(1'b0, 64'h0000_0000_8300_0080);
        wr(1'b1, 64'h0);
        for (int i = 0; i < 12; i++) begin occ_inc = (i % 4 < 2) ? 5'd1 : 5'd4; tick(); end
        rd_sel = 1'b1; #0.5;
        chk("R6 rises", rd_data, 64'd3);
        run_occ(40);

        // R7: falling transitions of occ >= 3
        tag = "R7";
        wr(1'b0, 64'h0000_0000_C300_0080);
        occ_inc = 5'd4; tick();
        wr(1'b1, 64'h0);
        for (int i = 0; i < 12; i++) begin occ_inc = (i % 4 < 2) ? 5'd1 : 5'd4; tick(); end
        rd_sel = 1'b1; #0.5;
        chk("R7 falls", rd_data, 64'd3);
        run_occ(40);

        // R8: enabling detect with condition already true gives no count
        tag = "R8";
        occ_inc = 5'd5;
        wr(1'b0, 64'h0000_0000_0300_0080);
        tick(); tick();
        wr(1'b0, 64'h0000_0000_8300_0080);
        rd_sel = 1'b1; #0.5;
        snap = rd_data[47:0];
        repeat (4) tick();
        rd_sel = 1'b1; #0.5;
        chk("R8 no spurious", rd_data, {16'h0, snap});

        // R9: clear while counting
        tag = "R9";
        wr(1'b0, 64'h0000_0000_0000_0080);
        repeat (5) tick();
        wr(1'b0, 64'h0000_0000_0002_0080);
        rd_sel = 1'b1; #0.5;
        chk("R9 clear", rd_data, 64'd0);
        rd_sel = 1'b0; #0.5;
        chk("R9 bit reads 0", rd_data, 64'h80);
        tick();

        // R10: load ignores upper bits, beats increment
        tag = "R10";
        wr(1'b1, 64'hFFFF_1234_5678_9ABC);
        rd_sel = 1'b1; #0.5;
        chk("R10 load", rd_data, 64'h0000_1234_5678_9ABC);

        // R11: wrap
        tag = "R11";
        wr(1'b0, 64'h0000_0000_0000_0001);
        evt_in = 1'b1;
        wr(1'b1, 64'h0000_FFFF_FFFF_FFFE);
        tick(); tick();
        rd_sel = 1'b1; #0.5;
        chk("R11 wrap", rd_data, 64'd0);
        tick();
        rd_sel = 1'b1; #0.5;
        chk("R11 after wrap", rd_data, 64'd1);

        // R12: mixed configs, writes during activity
        tag = "R12";
        for (int k = 0; k < 40; k++) begin
            wr(1'b0, {32'h0, 2'($urandom), 1'b1, 5'($urandom_range(0, 6)), 16'h0, 1'($urandom), 7'h0});
            run_occ(15);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule